// File: doc/BRIEF.md
# Jump-Counter State Sequencer

This block is a control sequencer whose state register is a loadable binary counter. There is no general next-state logic. On every clock edge the counter does one of four things: it clears to the idle state, loads a jump target, increments to the next sequential state, or holds. Three per-state selectors choose these actions. Each selector is indexed by the current state and picks either a constant or one of the condition inputs, optionally inverted. The selector outputs are active-low, in the manner of a board-level counter with low-true clear and load pins.

The count pin of the counter is active-high. Because each selector inverts its data, the count selector table is stored in inverted sense. A jump-target table gives two targets per state. In the hybrid variant (`HYBRID=1`), a fourth per-state selector, the branch selector, chooses between the two targets, so a load depends on both the state and the conditions. In the pure variant (`HYBRID=0`), the first target is always used, so the jump address depends only on the state.

The selector and target tables are parameters. By default they hold a 16-state example machine whose states have names. There are three conditions: `cond[0]` go, `cond[1]` done and `cond[2]` err.

Top module: `jc_sequencer`

## Requirements
- R1: `rst` is synchronous and active-high. It is ORed with the clear-selector term, so a clock edge with `rst` high leaves `state` at 0 (IDLE), whatever the conditions and tables.
- R2: When the clear selector's data is 1 for the current state (its active-low output is 0), the next state is 0.
- R3: Clear has priority over load and count. In VERIFY (4) with err=1, the next state is 0, even though load is also active when done=0.
- R4: Load has priority over count. In VERIFY (4) with err=0 and done=0, the next state is the jump target 2 (PROBE), not 5.
- R5: When clear and load are inactive and the count pin is high, the state increments by one. It wraps from 15 (LAST) to 0.
- R6: When clear and load are inactive and the count pin is low, the state holds, for as many cycles as the conditions stay. For example, WAIT (3) holds while done=0.
- R7: Hybrid mode: on a load, the second target is used when the branch selector's data is 1, and the first target otherwise. The example uses PROBE(2) with err=1, which goes to 9 when done=1 and to 6 when done=0. It also uses FORK(8) with go=1, which goes to 10 when err=0 and to 12 when err=1. A third case is SPLIT(12) with done=1, which goes to 3 when go=1 and to 14 when go=0.
- R8: Pure mode (`HYBRID=0`): a load always takes the first target. With the same tables, PROBE's load goes to 6, FORK's to 12 and SPLIT's to 14, whatever the conditions.
- R9: The selector codes have CODE_W bits. The low bits select the source: 0 is constant 0, and k is cond[k-1]. The top bit inverts the source. Each selector output is the inverse of its data. The count table is stored inverted: count code 0 means always count, and code 4 (inverted constant 0) means never count. In the example, PARK(9) stores "not go" and so advances on go=1 and holds on go=0. FLUSH(6) clears on go=0.
- R10: With the default tables, the next state from every state (0..15) under every one of the 8 condition combinations matches the example transition table, in both variants.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active-high, merged into the clear |
| cond | input | NUM_COND | Condition inputs (default: [0] go, [1] done, [2] err) |
| state | output | STATE_W | Current counter state |

## Verification
The bench walks every state under all eight condition combinations and compares both variants against an independently written transition table. A design with inverted selector polarity, or with a count table that is not stored inverted, would count where it should hold and would fail across whole rows. Directed cases target VERIFY, where clear, load and count are all requested at once. A swapped priority would land on 2 or 5 instead of 0, or on 5 instead of 2. Other directed cases cover the wrap from LAST to IDLE, where a counter without a clean modulo wrap would go astray. They also cover reset asserted in a state that is about to load, and branch-target selection, where a pure design would ignore done and a wrong select sense would swap 6 and 9.

// File: rtl/jc_pkg.sv
package jc_pkg;

    // Counter action chosen each cycle, in priority order of evaluation
    typedef enum logic [1:0] {
        OP_HOLD  = 2'd0,
        OP_COUNT = 2'd1,
        OP_LOAD  = 2'd2,
        OP_CLEAR = 2'd3
    } jc_op_e;

    // Example machine state names (4-bit counter)
    typedef enum logic [3:0] {
        ST_IDLE   = 4'd0,
        ST_ARM    = 4'd1,
        ST_PROBE  = 4'd2,
        ST_WAIT   = 4'd3,
        ST_VERIFY = 4'd4,
        ST_ADV5   = 4'd5,
        ST_FLUSH  = 4'd6,
        ST_ADV7   = 4'd7,
        ST_FORK   = 4'd8,
        ST_PARK   = 4'd9,
        ST_RUN10  = 4'd10,
        ST_RUN11  = 4'd11,
        ST_SPLIT  = 4'd12,
        ST_RUN13  = 4'd13,
        ST_RUN14  = 4'd14,
        ST_LAST   = 4'd15
    } jc_state_e;

    localparam int EX_NS     = 16;
    localparam int EX_CODE_W = 3;

    // Selector codes for three conditions: {invert, source}
    localparam logic [2:0] K_OFF   = 3'b000;
    localparam logic [2:0] K_ON    = 3'b100;
    localparam logic [2:0] K_GO    = 3'b001;
    localparam logic [2:0] K_DONE  = 3'b010;
    localparam logic [2:0] K_ERR   = 3'b011;
    localparam logic [2:0] K_NGO   = 3'b101;
    localparam logic [2:0] K_NDONE = 3'b110;
    localparam logic [2:0] K_NERR  = 3'b111;

    function automatic logic [EX_NS-1:0][EX_CODE_W-1:0] ex_clr_tbl();
        logic [EX_NS-1:0][EX_CODE_W-1:0] t;
        for (int i = 0; i < EX_NS; i++) t[i] = K_OFF;
        t[ST_VERIFY] = K_ERR;
        t[ST_FLUSH]  = K_NGO;
        t[ST_PARK]   = K_ERR;
        return t;
    endfunction

    function automatic logic [EX_NS-1:0][EX_CODE_W-1:0] ex_ld_tbl();
        logic [EX_NS-1:0][EX_CODE_W-1:0] t;
        for (int i = 0; i < EX_NS; i++) t[i] = K_OFF;
        t[ST_PROBE]  = K_ERR;
        t[ST_VERIFY] = K_NDONE;
        t[ST_FORK]   = K_GO;
        t[ST_SPLIT]  = K_DONE;
        return t;
    endfunction

    // Stored in inverted sense: a 0 at the selector data means count
    function automatic logic [EX_NS-1:0][EX_CODE_W-1:0] ex_cnt_tbl();
        logic [EX_NS-1:0][EX_CODE_W-1:0] t;
        for (int i = 0; i < EX_NS; i++) t[i] = K_OFF;
        t[ST_IDLE] = K_NGO;
        t[ST_WAIT] = K_NDONE;
        t[ST_PARK] = K_NGO;
        return t;
    endfunction

    function automatic logic [EX_NS-1:0][EX_CODE_W-1:0] ex_br_tbl();
        logic [EX_NS-1:0][EX_CODE_W-1:0] t;
        for (int i = 0; i < EX_NS; i++) t[i] = K_OFF;
        t[ST_PROBE] = K_DONE;
        t[ST_FORK]  = K_NERR;
        t[ST_SPLIT] = K_GO;
        return t;
    endfunction

    function automatic logic [EX_NS-1:0][3:0] ex_tgt0_tbl();
        logic [EX_NS-1:0][3:0] t;
        for (int i = 0; i < EX_NS; i++) t[i] = ST_IDLE;
        t[ST_PROBE]  = ST_FLUSH;
        t[ST_VERIFY] = ST_PROBE;
        t[ST_FORK]   = ST_SPLIT;
        t[ST_SPLIT]  = ST_RUN14;
        return t;
    endfunction

    function automatic logic [EX_NS-1:0][3:0] ex_tgt1_tbl();
        logic [EX_NS-1:0][3:0] t;
        for (int i = 0; i < EX_NS; i++) t[i] = ST_IDLE;
        t[ST_PROBE] = ST_PARK;
        t[ST_FORK]  = ST_RUN10;
        t[ST_SPLIT] = ST_WAIT;
        return t;
    endfunction

endpackage

// File: rtl/jc_ctl_mux.sv
module jc_ctl_mux #(
    parameter int STATE_W  = 4,
    parameter int NUM_COND = 3,
    parameter int CODE_W   = 3
) (
    input  logic [(1<<STATE_W)-1:0][CODE_W-1:0] tbl,
    input  logic [STATE_W-1:0]                  state,
    input  logic [NUM_COND-1:0]                 cond,
    output logic                                ctl_n
);
    localparam int SEL_W = CODE_W - 1;

    logic [CODE_W-1:0] code;
    logic              src_bit;
    logic              data;

    always_comb begin
        code    = tbl[state];
        src_bit = 1'b0;
        for (int k = 0; k < NUM_COND; k++) begin
            if (code[SEL_W-1:0] == SEL_W'(k + 1)) src_bit = cond[k];
        end
        data  = src_bit ^ code[CODE_W-1];
        ctl_n = ~data;
    end
endmodule

// File: rtl/jc_jump_sel.sv
module jc_jump_sel #(
    parameter int STATE_W = 4
) (
    input  logic [(1<<STATE_W)-1:0][STATE_W-1:0] tgt0_tbl,
    input  logic [(1<<STATE_W)-1:0][STATE_W-1:0] tgt1_tbl,
    input  logic [STATE_W-1:0]                   state,
    input  logic                                 take_alt_n,
    output logic [STATE_W-1:0]                   target
);
    always_comb begin
        if (!take_alt_n) target = tgt1_tbl[state];
        else             target = tgt0_tbl[state];
    end
endmodule

// File: rtl/jc_counter.sv
module jc_counter #(
    parameter int W = 4
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         clr_n,
    input  logic         ld_n,
    input  logic         cnt,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    import jc_pkg::*;

    jc_op_e op;

    always_comb begin
        if (rst || !clr_n) op = OP_CLEAR;
        else if (!ld_n)    op = OP_LOAD;
        else if (cnt)      op = OP_COUNT;
        else               op = OP_HOLD;
    end

    always_ff @(posedge clk) begin
        unique case (op)
            OP_CLEAR: q <= '0;
            OP_LOAD:  q <= d;
            OP_COUNT: q <= q + 1'b1;
            OP_HOLD:  q <= q;
            default:  q <= '0;
        endcase
    end
endmodule

// File: rtl/jc_sequencer.sv
module jc_sequencer #(
    parameter int STATE_W  = 4,
    parameter int NUM_COND = 3,
    parameter bit HYBRID   = 1'b1,
    parameter logic [(1<<STATE_W)-1:0][$clog2(NUM_COND+1):0] CLR_TBL  = jc_pkg::ex_clr_tbl(),
    parameter logic [(1<<STATE_W)-1:0][$clog2(NUM_COND+1):0] LD_TBL   = jc_pkg::ex_ld_tbl(),
    parameter logic [(1<<STATE_W)-1:0][$clog2(NUM_COND+1):0] CNT_TBL  = jc_pkg::ex_cnt_tbl(),
    parameter logic [(1<<STATE_W)-1:0][$clog2(NUM_COND+1):0] BR_TBL   = jc_pkg::ex_br_tbl(),
    parameter logic [(1<<STATE_W)-1:0][STATE_W-1:0]          TGT0_TBL = jc_pkg::ex_tgt0_tbl(),
    parameter logic [(1<<STATE_W)-1:0][STATE_W-1:0]          TGT1_TBL = jc_pkg::ex_tgt1_tbl()
) (
    input  logic                clk,
    input  logic                rst,
    input  logic [NUM_COND-1:0] cond,
    output logic [STATE_W-1:0]  state
);
    localparam int NS     = 1 << STATE_W;
    localparam int CODE_W = $clog2(NUM_COND + 1) + 1;
    localparam int N_CTL  = 3;  // 0 clear, 1 load, 2 count

    localparam logic [N_CTL-1:0][NS-1:0][CODE_W-1:0] CTL_TBL = {CNT_TBL, LD_TBL, CLR_TBL};

    logic [N_CTL-1:0]   ctl_n;
    logic               clr_n;
    logic               ld_n;
    logic               cnt_en;
    logic               br_n;
    logic [STATE_W-1:0] jmp_tgt;
    logic [STATE_W-1:0] cur;

    for (genvar g = 0; g < N_CTL; g++) begin : g_ctl
        jc_ctl_mux #(
            .STATE_W (STATE_W),
            .NUM_COND(NUM_COND),
            .CODE_W  (CODE_W)
        ) u_mux (
            .tbl  (CTL_TBL[g]),
            .state(cur),
            .cond (cond),
            .ctl_n(ctl_n[g])
        );
    end

    // Clear and load pins are low-true; the count pin is high-true, which
    // the inverted count table compensates for.
    assign clr_n  = ctl_n[0];
    assign ld_n   = ctl_n[1];
    assign cnt_en = ctl_n[2];

    if (HYBRID) begin : g_hybrid
        jc_ctl_mux #(
            .STATE_W (STATE_W),
            .NUM_COND(NUM_COND),
            .CODE_W  (CODE_W)
        ) u_br (
            .tbl  (BR_TBL),
            .state(cur),
            .cond (cond),
            .ctl_n(br_n)
        );
    end else begin : g_pure
        assign br_n = 1'b1;
    end

    jc_jump_sel #(.STATE_W(STATE_W)) u_jump (
        .tgt0_tbl  (TGT0_TBL),
        .tgt1_tbl  (TGT1_TBL),
        .state     (cur),
        .take_alt_n(br_n),
        .target    (jmp_tgt)
    );

    jc_counter #(.W(STATE_W)) u_cnt (
        .clk  (clk),
        .rst  (rst),
        .clr_n(clr_n),
        .ld_n (ld_n),
        .cnt  (cnt_en),
        .d    (jmp_tgt),
        .q    (cur)
    );

    always_comb state = cur;
endmodule

// File: rtl/jc_sequencer_chk.sv
module jc_sequencer_chk #(
    parameter int STATE_W = 4
) (
    input logic               clk,
    input logic               rst,
    input logic [STATE_W-1:0] state,
    input logic               clr_n,
    input logic               ld_n,
    input logic               cnt_en,
    input logic [STATE_W-1:0] jmp_tgt
);
    // R2: an active clear selector sends the counter to 0
    a_r2_clear_to_idle: assert property (@(posedge clk) disable iff (rst)
        !clr_n |=> state == '0);

    // R3: clear wins even while load is also requested
    a_r3_clear_over_load: assert property (@(posedge clk) disable iff (rst)
        (!clr_n && !ld_n) |=> state == '0);

    // R4: load alone takes the jump target
    a_r4_load_target: assert property (@(posedge clk) disable iff (rst)
        (clr_n && !ld_n) |=> state == $past(jmp_tgt));

    // R5: count increments with modulo wrap
    a_r5_count_step: assert property (@(posedge clk) disable iff (rst)
        (clr_n && ld_n && cnt_en) |=> state == STATE_W'($past(state) + 1'b1));

    // R6: with no control active the state is kept
    a_r6_hold: assert property (@(posedge clk) disable iff (rst)
        (clr_n && ld_n && !cnt_en) |=> $stable(state));
endmodule

bind jc_sequencer jc_sequencer_chk #(.STATE_W(STATE_W)) u_chk (
    .clk    (clk),
    .rst    (rst),
    .state  (state),
    .clr_n  (clr_n),
    .ld_n   (ld_n),
    .cnt_en (cnt_en),
    .jmp_tgt(jmp_tgt)
);

// File: tb/sim_jc_sequencer.sv
`timescale 1ns/1ps
module sim_jc_sequencer;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [2:0] cond = 3'b111;
    logic [3:0] st_h;
    logic [3:0] st_p;
    int         n_cmp = 0;
    int         n_bad = 0;
    bit         done_flag = 1'b0;

    always #10 clk = ~clk;  // 50 MHz

    jc_sequencer u0 (.clk(clk), .rst(rst), .cond(cond), .state(st_h));
    jc_sequencer #(.HYBRID(1'b0)) u1 (.clk(clk), .rst(rst), .cond(cond), .state(st_p));

    // cond bits: [0] go, [1] done, [2] err
    // Walking vectors: the condition that moves state i to i+1 without a jump
    localparam logic [2:0] NAV [16] = '{
        3'b001, 3'b000, 3'b000, 3'b010, 3'b010, 3'b000, 3'b001, 3'b000,
        3'b000, 3'b001, 3'b000, 3'b000, 3'b000, 3'b000, 3'b000, 3'b000
    };

    // Example transition table written from the requirements
    function automatic int ref_next(input int s, input logic [2:0] c, input bit hyb);
        bit go, dn, er;
        go = c[0]; dn = c[1]; er = c[2];
        case (s)
            0:  return go ? 1 : 0;
            2:  return er ? ((hyb && dn) ? 9 : 6) : 3;
            3:  return dn ? 4 : 3;
            4:  return er ? 0 : (!dn ? 2 : 5);
            6:  return go ? 7 : 0;
            8:  return go ? ((hyb && !er) ? 10 : 12) : 9;
            9:  return er ? 0 : (go ? 10 : 9);
            12: return dn ? ((hyb && go) ? 3 : 14) : 13;
            15: return 0;
            default: return s + 1;
        endcase
    endfunction

    task automatic chk(input string tag, input int act, input int exp);
        n_cmp++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: got %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic goto(input int s);
        rst  = 1'b1;
        cond = 3'b000;
        @(negedge clk);
        rst = 1'b0;
        for (int i = 0; i < s; i++) begin
            cond = NAV[i];
            @(negedge clk);
        end
    endtask

    task automatic step(input logic [2:0] c);
        cond = c;
        @(negedge clk);
    endtask

    initial begin
        // R1: reset with all conditions high
        @(negedge clk);
        @(negedge clk);
        chk("R1 reset state hybrid", st_h, 0);
        chk("R1 reset state pure", st_p, 0);

        // R10: every state under every condition combination, both variants
        for (int s = 0; s < 16; s++) begin
            for (int c = 0; c < 8; c++) begin
                goto(s);
                step(3'(c));
                chk("R10 table hybrid", st_h, ref_next(s, 3'(c), 1'b1));
                chk("R10 table pure", st_p, ref_next(s, 3'(c), 1'b0));
            end
        end

        // R1: reset in PROBE where err would load
        goto(2);
        rst = 1'b1; step(3'b111); rst = 1'b0;
        chk("R1 reset over load", st_h, 0);
        // R1: reset in IDLE with go high must not count
        rst = 1'b1; step(3'b001); rst = 1'b0;
        chk("R1 reset over count", st_h, 0);

        // R2: FLUSH clears on go=0
        goto(6); step(3'b000);
        chk("R2 flush clear", st_h, 0);

        // R3: VERIFY with err and done=0: clear beats load
        goto(4); step(3'b100);
        chk("R3 clear over load", st_h, 0);

        // R4: VERIFY err=0 done=0 loads 2
        goto(4); step(3'b000);
        chk("R4 load over count", st_h, 2);

        // R5: wrap LAST -> IDLE and plain increment
        goto(15); step(3'b000);
        chk("R5 wrap", st_h, 0);
        goto(10); step(3'b111);
        chk("R5 increment", st_h, 11);

        // R6: WAIT holds several cycles while done=0
        goto(3);
        for (int i = 0; i < 3; i++) begin
            step(3'b101);
            chk("R6 hold", st_h, 3);
        end

        // R7: hybrid target select
        goto(2); step(3'b110);
        chk("R7 probe alt target", st_h, 9);
        goto(2); step(3'b100);
        chk("R7 probe base target", st_h, 6);
        goto(8); step(3'b001);
        chk("R7 fork alt target", st_h, 10);

        // R8: pure mode ignores conditions for target
        goto(2); step(3'b110);
        chk("R8 pure probe", st_p, 6);
        goto(12); step(3'b011);
        chk("R8 pure split", st_p, 14);

        // R9: inverted count storage in PARK, constant-high clear selector effect
        goto(9); step(3'b000);
        chk("R9 park holds", st_h, 9);
        step(3'b001);
        chk("R9 park counts", st_h, 10);
        goto(0); step(3'b000);
        chk("R9 idle holds on go low", st_h, 0);

        done_flag = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done_flag) begin
            n_cmp++;
            n_bad++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end
endmodule